// File: doc/BRIEF.md
# Binary and Packed-Decimal Add/Subtract Unit

This unit adds with carry or subtracts with borrow on two operands, either as plain binary numbers or as packed decimal digits (four bits per digit). One start pulse launches an operation. The operands, carry-in, operation select and decimal flag are sampled in that start cycle and need not be held afterwards. The unit then returns the result and the carry, overflow, negative and zero flags, together with a one-cycle done pulse.

A binary operation finishes on the clock edge that samples the start pulse. A decimal operation runs one digit per clock through a single shared digit stage, lowest digit first, so it finishes one edge per digit after the start. The digit count is set by a parameter (at least 2, default 2, so 8-bit operands). The result and flag outputs are registered and keep their values until the next operation completes. The carry-in and carry-out follow the usual convention for subtract: a 1 means "no borrow".

Top module: `dec_arith_unit`

## Requirements
- R1: Binary add (`sub_i`=0, `dec_i`=0): `res_o` = (A + M + C) mod 256 and `carry_o` = bit 8 of that 9-bit sum.
- R2: Binary add overflow: `ovf_o` = bit 7 of (R xor A) and (R xor M), where R is the 8-bit result.
- R3: Binary subtract (`sub_i`=1, `dec_i`=0): the unit forms A + (not M) + C. `res_o` is its low 8 bits, `carry_o` is bit 8, and `ovf_o` = bit 7 of (R xor A) and (R xor not M).
- R4: Decimal add (`sub_i`=0, `dec_i`=1): for each digit, lowest first, the sum s = a + m + incoming carry is formed. If s is 10 or more, the digit becomes (s + 6) mod 16 and a carry of 1 passes to the next digit. `carry_o` is the carry out of the top digit.
- R5: Decimal add overflow: `ovf_o` = bit 7 of (P xor A) and (P xor M). P is built from each digit's sum s mod 16, taken before that digit is corrected.
- R6: Decimal subtract (`sub_i`=1, `dec_i`=1): the initial borrow is not C. For each digit, d = a - m - borrow. If d is negative, the digit becomes (d - 6) mod 16 and a borrow passes upward. `carry_o` = not (borrow out of the top digit).
- R7: Decimal subtract overflow: with D = (A - M - (not C)) mod 256, `ovf_o` = bit 7 of (D xor A) and ((not D) xor M).
- R8: In every mode, `neg_o` equals bit 7 of `res_o`, and `zero_o` is 1 exactly when `res_o` is 0.
- R9: A binary operation accepted on clock edge k raises `done_o` for the cycle that follows edge k.
- R10: A decimal operation accepted on edge k takes one edge per digit: `done_o` rises after edge k+1 (default 2 digits) and is low after edge k.
- R11: A start pulse that arrives while a decimal operation is still in progress is ignored: it produces no result and no done pulse, and it does not change the running operation. A start in the cycle that carries a done pulse is accepted.
- R12: After reset, `res_o`, `carry_o`, `ovf_o` and `done_o` are 0 and `zero_o` is 1. The result and flags change only on the edge that raises `done_o` and hold at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch an operation (one cycle) |
| sub_i | input | 1 | 0 = add with carry, 1 = subtract with borrow |
| dec_i | input | 1 | 1 = packed-decimal mode |
| a_i | input | 8 | First operand |
| m_i | input | 8 | Second operand |
| carry_i | input | 1 | Carry-in (1 = no borrow for subtract) |
| res_o | output | 8 | Result |
| carry_o | output | 1 | Carry-out |
| ovf_o | output | 1 | Overflow flag |
| neg_o | output | 1 | Negative flag |
| zero_o | output | 1 | Zero flag |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Completing a decimal operation and accepting the next start can happen in the same cycle. A start can also collide with the middle digit step of a decimal operation. The bench drives a decimal start, then a second start in the busy cycle that must be dropped, then a binary start in the very cycle that carries the done pulse. The scoreboard expects exactly two results: the decimal one on the second edge and the binary one on the next edge. Any extra or misplaced done pulse, or a result tainted by the ignored operands, is reported.

// File: rtl/dau_pkg.sv
package dau_pkg;
    localparam int NIB       = 4;
    localparam int BCD_LIMIT = 10;
    localparam int BCD_ADJ   = 6;
endpackage

// File: rtl/dau_bin_path.sv
module dau_bin_path #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] m,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    logic [W-1:0] m_eff;
    logic [W:0]   s;
    logic [W-1:0] ov_vec;

    assign m_eff  = sub ? ~m : m;
    assign s      = {1'b0, a} + {1'b0, m_eff} + {{W{1'b0}}, cin};
    assign sum    = s[W-1:0];
    assign cout   = s[W];
    assign ov_vec = (sum ^ a) & (sum ^ m_eff);
    assign ovf    = ov_vec[W-1];
endmodule

// File: rtl/dau_digit_step.sv
module dau_digit_step
    import dau_pkg::*;
(
    input  logic [NIB-1:0] a_n,
    input  logic [NIB-1:0] m_n,
    input  logic           cin,
    input  logic           sub,
    output logic [NIB-1:0] res_n,
    output logic [NIB-1:0] raw_n,
    output logic           cout
);
    logic [NIB:0] s;

    // cin is a carry when adding and a borrow when subtracting
    assign s = sub ? ({1'b0, a_n} - {1'b0, m_n} - {{NIB{1'b0}}, cin})
                   : ({1'b0, a_n} + {1'b0, m_n} + {{NIB{1'b0}}, cin});
    assign raw_n = s[NIB-1:0];

    always_comb begin
        if (sub) begin
            cout  = s[NIB];
            res_n = cout ? raw_n - NIB'(BCD_ADJ) : raw_n;
        end else begin
            cout  = (s >= (NIB+1)'(BCD_LIMIT));
            res_n = cout ? raw_n + NIB'(BCD_ADJ) : raw_n;
        end
    end
endmodule

// File: rtl/dec_arith_unit.sv
module dec_arith_unit
    import dau_pkg::*;
#(
    parameter  int DIGITS = 2,
    localparam int W      = DIGITS * NIB,
    localparam int CW     = $clog2(DIGITS + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         sub_i,
    input  logic         dec_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] m_i,
    input  logic         carry_i,
    output logic [W-1:0] res_o,
    output logic         carry_o,
    output logic         ovf_o,
    output logic         neg_o,
    output logic         zero_o,
    output logic         done_o
);
    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
        logic          sub;
        logic [W-1:0]  a_sh;
        logic [W-1:0]  m_sh;
        logic [W-1:0]  a_full;
        logic [W-1:0]  m_full;
        logic [W-1:0]  acc;
        logic [W-1:0]  part;
        logic          cy;
        logic          dov;
        logic [W-1:0]  res;
        logic          carry;
        logic          ovf;
        logic          done;
    } st_t;

    st_t q, d;

    logic           take, last;
    logic [W-1:0]   src_a, src_m, base_acc, base_part, acc_n, part_n;
    logic [W-1:0]   bin_sum, dsub_diff, dsub_vec, dadd_vec;
    logic [NIB-1:0] nib_res, nib_raw;
    logic           nib_cin, nib_sub, nib_cout, bin_carry, bin_ovf;

    assign take      = start_i && !q.busy;
    assign last      = q.busy && (q.cnt == CW'(DIGITS - 1));
    assign src_a     = q.busy ? q.a_sh : a_i;
    assign src_m     = q.busy ? q.m_sh : m_i;
    assign nib_sub   = q.busy ? q.sub : sub_i;
    assign nib_cin   = q.busy ? q.cy : (sub_i ? ~carry_i : carry_i);
    assign base_acc  = q.busy ? q.acc : '0;
    assign base_part = q.busy ? q.part : '0;
    assign acc_n     = {nib_res, base_acc[W-1:NIB]};
    assign part_n    = {nib_raw, base_part[W-1:NIB]};
    assign dsub_diff = a_i - m_i - {{(W-1){1'b0}}, ~carry_i};
    assign dsub_vec  = (dsub_diff ^ a_i) & (~dsub_diff ^ m_i);
    assign dadd_vec  = (part_n ^ q.a_full) & (part_n ^ q.m_full);

    dau_bin_path #(.W(W)) u_bin (
        .a    (a_i),
        .m    (m_i),
        .cin  (carry_i),
        .sub  (sub_i),
        .sum  (bin_sum),
        .cout (bin_carry),
        .ovf  (bin_ovf)
    );

    dau_digit_step u_dig (
        .a_n   (src_a[NIB-1:0]),
        .m_n   (src_m[NIB-1:0]),
        .cin   (nib_cin),
        .sub   (nib_sub),
        .res_n (nib_res),
        .raw_n (nib_raw),
        .cout  (nib_cout)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (take && !dec_i) begin
            d.res   = bin_sum;
            d.carry = bin_carry;
            d.ovf   = bin_ovf;
            d.done  = 1'b1;
        end else if ((take && dec_i) || q.busy) begin
            d.a_sh = src_a >> NIB;
            d.m_sh = src_m >> NIB;
            d.acc  = acc_n;
            d.part = part_n;
            d.cy   = nib_cout;
            if (take) begin
                d.busy   = 1'b1;
                d.cnt    = CW'(1);
                d.sub    = sub_i;
                d.a_full = a_i;
                d.m_full = m_i;
                d.dov    = dsub_vec[W-1];
            end else if (last) begin
                d.busy  = 1'b0;
                d.cnt   = '0;
                d.res   = acc_n;
                d.carry = q.sub ? ~nib_cout : nib_cout;
                d.ovf   = q.sub ? q.dov : dadd_vec[W-1];
                d.done  = 1'b1;
            end else begin
                d.cnt = q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign res_o   = q.res;
    assign carry_o = q.carry;
    assign ovf_o   = q.ovf;
    assign neg_o   = q.res[W-1];
    assign zero_o  = (q.res == '0);
    assign done_o  = q.done;
endmodule

// File: rtl/dau_checker.sv
module dau_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start_i,
    input logic         dec_i,
    input logic         busy,
    input logic         done_o,
    input logic [W-1:0] res_o,
    input logic         carry_o,
    input logic         ovf_o
);
    p_bin_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !busy && !dec_i |=> done_o);

    p_dec_occupy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !busy && dec_i |=> busy && !done_o);

    p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy);

    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable({res_o, carry_o, ovf_o}));
endmodule

bind dec_arith_unit dau_checker #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .dec_i   (dec_i),
    .busy    (q.busy),
    .done_o  (done_o),
    .res_o   (res_o),
    .carry_o (carry_o),
    .ovf_o   (ovf_o)
);

// File: tb/sim_dec_arith_unit.sv
module sim_dec_arith_unit;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0, sub_i = 1'b0, dec_i = 1'b0, carry_i = 1'b0;
    logic [7:0] a_i = '0, m_i = '0;
    logic [7:0] res_o;
    logic       carry_o, ovf_o, neg_o, zero_o, done_o;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    typedef struct {
        logic [7:0] res;
        logic       c;
        logic       v;
        int         cyc;
        string      tr;
        string      tv;
        string      tl;
    } item_t;

    item_t      sbq[$];
    logic [7:0] last_res = '0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dec_arith_unit u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .sub_i(sub_i), .dec_i(dec_i),
        .a_i(a_i), .m_i(m_i), .carry_i(carry_i), .res_o(res_o), .carry_o(carry_o),
        .ovf_o(ovf_o), .neg_o(neg_o), .zero_o(zero_o), .done_o(done_o)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic item_t model(input bit sub, input bit dec, input int a, input int m, input int c);
        item_t it;
        int s, mm, lo, hi, k, p, b, dd;
        if (!dec) begin
            mm = sub ? (~m & 255) : m;
            s  = a + mm + c;
            it.res = 8'(s);
            it.c   = s[8];
            it.v   = ((s ^ a) & (s ^ mm)) >> 7 & 1;
            it.tr  = sub ? "R3" : "R1";
            it.tv  = sub ? "R3" : "R2";
        end else if (!sub) begin
            lo = a % 16 + m % 16 + c;
            p  = lo % 16;
            k  = 0;
            if (lo >= 10) begin lo = (lo + 6) % 16; k = 1; end
            hi = a / 16 + m / 16 + k;
            p  = p + (hi % 16) * 16;
            it.c = (hi >= 10);
            if (hi >= 10) hi = (hi + 6) % 16;
            it.res = 8'(hi * 16 + lo);
            it.v   = ((p ^ a) & (p ^ m)) >> 7 & 1;
            it.tr  = "R4";
            it.tv  = "R5";
        end else begin
            b  = (c == 0) ? 1 : 0;
            dd = (a - m - b) & 255;
            lo = a % 16 - m % 16 - b;
            k  = 0;
            if (lo < 0) begin lo = (lo - 6 + 32) % 16; k = 1; end
            hi = a / 16 - m / 16 - k;
            it.c = !(hi < 0);
            if (hi < 0) hi = (hi - 6 + 32) % 16;
            it.res = 8'(hi * 16 + lo);
            it.v   = ((dd ^ a) & (~dd ^ m)) >> 7 & 1;
            it.tr  = "R6";
            it.tv  = "R7";
        end
        it.tl  = dec ? "R10" : "R9";
        it.cyc = 0;
        return it;
    endfunction

    // driver: one start pulse; pushes the expected item if it must be accepted
    task automatic send(input bit sub, input bit dec, input int a, input int m, input bit c, input bit expect_acc);
        item_t it;
        @(negedge clk);
        start_i = 1'b1; sub_i = sub; dec_i = dec; a_i = 8'(a); m_i = 8'(m); carry_i = c;
        if (expect_acc) begin
            it = model(sub, dec, a, m, int'(c));
            it.cyc = cyc + (dec ? 2 : 1);
            sbq.push_back(it);
        end
        @(posedge clk);
        #1 start_i = 1'b0;
    endtask

    task automatic drain();
        while (sbq.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            if (sbq.size() == 0) begin
                chk("R11", "unexpected done", 1, 0);
            end else begin
                item_t it;
                it = sbq.pop_front();
                chk(it.tr, "result", int'(res_o), int'(it.res));
                chk(it.tr, "carry", int'(carry_o), int'(it.c));
                chk(it.tv, "overflow", int'(ovf_o), int'(it.v));
                chk("R8", "negative", int'(neg_o), int'(it.res[7]));
                chk("R8", "zero", int'(zero_o), int'(it.res == 8'h00));
                chk(it.tl, "done cycle", cyc, it.cyc);
                last_res = it.res;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        chk("WDOG", "watchdog expired", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        chk("R12", "reset result", int'(res_o), 0);
        chk("R12", "reset carry", int'(carry_o), 0);
        chk("R12", "reset done", int'(done_o), 0);
        chk("R12", "reset zero", int'(zero_o), 1);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2 binary add
        send(0, 0, 8'h10, 8'h20, 0, 1); drain();
        send(0, 0, 8'hFF, 8'h01, 0, 1); drain();
        send(0, 0, 8'h7F, 8'h01, 0, 1); drain();
        send(0, 0, 8'h80, 8'h80, 1, 1); drain();
        // R3 binary subtract
        send(1, 0, 8'h50, 8'h20, 1, 1); drain();
        send(1, 0, 8'h00, 8'h01, 1, 1); drain();
        send(1, 0, 8'h80, 8'h01, 1, 1); drain();
        send(1, 0, 8'h10, 8'h05, 0, 1); drain();
        // R4 R5 decimal add
        send(0, 1, 8'h19, 8'h28, 0, 1); drain();
        send(0, 1, 8'h99, 8'h01, 0, 1); drain();
        send(0, 1, 8'h58, 8'h46, 1, 1); drain();
        send(0, 1, 8'h79, 8'h00, 1, 1); drain();
        // R6 R7 decimal subtract
        send(1, 1, 8'h46, 8'h12, 1, 1); drain();
        send(1, 1, 8'h12, 8'h21, 1, 1); drain();
        send(1, 1, 8'h00, 8'h01, 1, 1); drain();
        send(1, 1, 8'h50, 8'h01, 0, 1); drain();

        // R12: outputs hold while idle
        repeat (5) @(negedge clk);
        chk("R12", "held result", int'(res_o), int'(last_res));

        // R11: busy start dropped, start in done cycle accepted
        send(0, 1, 8'h11, 8'h22, 0, 1);
        send(1, 1, 8'h99, 8'h99, 1, 0);
        send(0, 0, 8'h01, 8'h02, 0, 1);
        drain();
        repeat (4) @(negedge clk);
        chk("R11", "pending items", sbq.size(), 0);

        // mixed back-to-back traffic
        for (int i = 0; i < 24; i++) begin
            int x, y;
            x = ((i * 7) % 10) * 16 + (i * 3) % 10;
            y = ((i * 5 + 2) % 10) * 16 + (i * 9 + 1) % 10;
            send(i[0], i[1], x, y, i[2], 1);
            if (i[1]) @(negedge clk);
        end
        drain();
        chk("R12", "final queue empty", sbq.size(), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule